// File: doc/BRIEF.md
# Single-Owner Directory Bank

This block is a shared last-level bank in which each stored word also acts as its own coherence record. A one-bit tag per entry says how the word's field is to be read. When the tag is clear, the field is the current data. When the tag is set, the field is the index of the one core that holds the up-to-date copy. The bank never keeps a list of sharers and has no in-between protocol states. Lines are one word wide.

Private caches send three kinds of request on per-core channels. A read gets the data at once when the bank holds it. When a core owns the word, the read is passed to that core on the forward channel, and the owner answers the requester directly. A claim makes the requesting core the owner and tells any earlier owner to release the word. A write-back from the current owner puts the data back in the bank. At most one request is taken per clock, and a fixed-priority arbiter decides which core goes first.

Top module: `regdir_bank`

## Requirements
- R1: When several cores present requests, only the lowest-indexed one sees `req_ready` high, in the same cycle, and exactly one request is taken per clock.
- R2: A read (op 2'b00) of a word whose tag is clear produces, one clock after acceptance, `rsp_valid` with `rsp_kind`=0 (data), `rsp_core` equal to the requester and `rsp_data` equal to the stored word, with no forward.
- R3: A claim (op 2'b01) from core C marks the word as owned by C and produces, one clock later, `rsp_valid` with `rsp_kind`=1 (claim acknowledge), `rsp_core`=C and `rsp_data`=0.
- R4: A claim from C of a word owned by a different core O also raises, in the same cycle as the acknowledge, `fwd_valid` with `fwd_kind`=1 (release), `fwd_core`=O and `fwd_addr` equal to the word's address.
- R5: A read of an owned word produces, one clock later, `fwd_valid` with `fwd_kind`=0 (forwarded read), `fwd_core` equal to the owner, `fwd_requester` equal to the reader and `fwd_addr` equal to the address, and no `rsp_valid`.
- R6: A write-back (op 2'b10) from the owner stores its data and clears the tag, so a later read returns that data. The write-back itself produces no response and no forward.
- R7: A write-back from a core that does not own the word is ignored. The word stays owned by its owner, and its stored contents do not change.
- R8: Op 2'b11 is accepted but has no effect on the stored word and produces no response or forward.
- R9: Reset clears `rsp_valid` and `fwd_valid` and clears every tag, so any read after reset is answered from the bank rather than forwarded.
- R10: A cycle in which no request is taken is followed by a cycle with `rsp_valid` and `fwd_valid` both low.
- R11: A claim from the core that already owns the word is acknowledged without any release forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CORES | Per-core request present |
| req_ready | output | NUM_CORES | Per-core acceptance this cycle (one-hot or zero) |
| req_op | input | NUM_CORES x 2 | Per-core opcode: 00 read, 01 claim, 10 write-back, 11 no-op |
| req_addr | input | NUM_CORES x AW | Per-core word address |
| req_wdata | input | NUM_CORES x DATA_W | Per-core write-back data |
| rsp_valid | output | 1 | Response present |
| rsp_core | output | CW | Core the response is for |
| rsp_kind | output | 1 | 0 data, 1 claim acknowledge |
| rsp_data | output | DATA_W | Read data, zero on acknowledge |
| fwd_valid | output | 1 | Forward message present |
| fwd_kind | output | 1 | 0 forwarded read, 1 release notice |
| fwd_core | output | CW | Core the forward is sent to |
| fwd_requester | output | CW | Core that caused the forward |
| fwd_addr | output | AW | Word address of the forward |

## Verification
The assertions assume that every core holds its request steady until `req_ready` shows that it was taken. They also assume that software never sends a write-back for data that was not first claimed, and that a core does not read a word it owns. The stimulus drives each request for exactly the cycle in which it is granted. Competing requests are held until their turn comes. Write-backs are sent only after a claim, except in the deliberate stale case that R7 describes.

// File: rtl/regdir_pkg.sv
package regdir_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_CLAIM = 2'b01,
    OP_WBACK = 2'b10,
    OP_NOP   = 2'b11
  } bank_op_e;

  localparam logic RSP_DATA    = 1'b0;
  localparam logic RSP_ACK     = 1'b1;
  localparam logic FWD_READ    = 1'b0;
  localparam logic FWD_RELEASE = 1'b1;

  localparam logic TAG_DATA  = 1'b0;
  localparam logic TAG_OWNED = 1'b1;

endpackage

// File: rtl/regdir_arbiter.sv
module regdir_arbiter #(
  parameter int NUM_CORES = 4,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] req_valid,
  output logic [NUM_CORES-1:0] grant,
  output logic [CW-1:0]        grant_idx,
  output logic                 any_grant
);

  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (req_valid[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = CW'(i);
      end
    end
    any_grant = |req_valid;
  end

  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_grant_needs_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req_valid) == '0);

endmodule

// File: rtl/regdir_store.sv
module regdir_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  output logic              rd_tag,
  output logic [DATA_W-1:0] rd_field,
  input  logic              we,
  input  logic              wr_tag,
  input  logic [DATA_W-1:0] wr_field
);

  // Tags are a small resettable register file; fields form a plain RAM.
  logic [DEPTH-1:0]  tag_q;
  logic [DATA_W-1:0] field_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (we) begin
      tag_q[addr] <= wr_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      field_mem[addr] <= wr_field;
    end
  end

  assign rd_tag   = tag_q[addr];
  assign rd_field = field_mem[addr];

endmodule

// File: rtl/regdir_engine.sv
module regdir_engine
  import regdir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              accept,
  input  logic [1:0]        op,
  input  logic [CW-1:0]     who,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_tag,
  input  logic [DATA_W-1:0] rd_field,
  output logic              we,
  output logic              wr_tag,
  output logic [DATA_W-1:0] wr_field,
  output logic              n_rsp_valid,
  output logic              n_rsp_kind,
  output logic [DATA_W-1:0] n_rsp_data,
  output logic              n_fwd_valid,
  output logic              n_fwd_kind,
  output logic [CW-1:0]     n_fwd_core
);

  logic [CW-1:0] owner;
  logic          owned;
  bank_op_e      op_e;

  assign owner = rd_field[CW-1:0];
  assign owned = (rd_tag == TAG_OWNED);
  assign op_e  = bank_op_e'(op);

  always_comb begin
    we          = 1'b0;
    wr_tag      = rd_tag;
    wr_field    = rd_field;
    n_rsp_valid = 1'b0;
    n_rsp_kind  = RSP_DATA;
    n_rsp_data  = '0;
    n_fwd_valid = 1'b0;
    n_fwd_kind  = FWD_READ;
    n_fwd_core  = owner;
    if (accept) begin
      case (op_e)
        OP_READ: begin
          if (owned) begin
            n_fwd_valid = 1'b1;
            n_fwd_kind  = FWD_READ;
          end else begin
            n_rsp_valid = 1'b1;
            n_rsp_kind  = RSP_DATA;
            n_rsp_data  = rd_field;
          end
        end
        OP_CLAIM: begin
          we          = 1'b1;
          wr_tag      = TAG_OWNED;
          wr_field    = DATA_W'(who);
          n_rsp_valid = 1'b1;
          n_rsp_kind  = RSP_ACK;
          if (owned && owner != who) begin
            n_fwd_valid = 1'b1;
            n_fwd_kind  = FWD_RELEASE;
          end
        end
        OP_WBACK: begin
          if (owned && owner == who) begin
            we       = 1'b1;
            wr_tag   = TAG_DATA;
            wr_field = wdata;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/regdir_bank.sv
module regdir_bank
  import regdir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 32,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_CORES-1:0]              req_valid,
  output logic [NUM_CORES-1:0]              req_ready,
  input  logic [NUM_CORES-1:0][1:0]         req_op,
  input  logic [NUM_CORES-1:0][AW-1:0]      req_addr,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]  req_wdata,
  output logic                              rsp_valid,
  output logic [CW-1:0]                     rsp_core,
  output logic                              rsp_kind,
  output logic [DATA_W-1:0]                 rsp_data,
  output logic                              fwd_valid,
  output logic                              fwd_kind,
  output logic [CW-1:0]                     fwd_core,
  output logic [CW-1:0]                     fwd_requester,
  output logic [AW-1:0]                     fwd_addr
);

  logic [NUM_CORES-1:0] grant;
  logic [CW-1:0]        widx;
  logic                 accept;
  logic [1:0]           sel_op;
  logic [AW-1:0]        sel_addr;
  logic [DATA_W-1:0]    sel_wdata;

  regdir_arbiter #(.NUM_CORES(NUM_CORES)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .grant     (grant),
    .grant_idx (widx),
    .any_grant (accept)
  );

  assign req_ready = grant;
  assign sel_op    = req_op[widx];
  assign sel_addr  = req_addr[widx];
  assign sel_wdata = req_wdata[widx];

  logic              rd_tag;
  logic [DATA_W-1:0] rd_field;
  logic              we;
  logic              wr_tag;
  logic [DATA_W-1:0] wr_field;

  regdir_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .addr     (sel_addr),
    .rd_tag   (rd_tag),
    .rd_field (rd_field),
    .we       (we),
    .wr_tag   (wr_tag),
    .wr_field (wr_field)
  );

  logic              n_rsp_valid;
  logic              n_rsp_kind;
  logic [DATA_W-1:0] n_rsp_data;
  logic              n_fwd_valid;
  logic              n_fwd_kind;
  logic [CW-1:0]     n_fwd_core;

  regdir_engine #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_eng (
    .accept      (accept),
    .op          (sel_op),
    .who         (widx),
    .wdata       (sel_wdata),
    .rd_tag      (rd_tag),
    .rd_field    (rd_field),
    .we          (we),
    .wr_tag      (wr_tag),
    .wr_field    (wr_field),
    .n_rsp_valid (n_rsp_valid),
    .n_rsp_kind  (n_rsp_kind),
    .n_rsp_data  (n_rsp_data),
    .n_fwd_valid (n_fwd_valid),
    .n_fwd_kind  (n_fwd_kind),
    .n_fwd_core  (n_fwd_core)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_core      <= '0;
      rsp_kind      <= RSP_DATA;
      rsp_data      <= '0;
      fwd_valid     <= 1'b0;
      fwd_kind      <= FWD_READ;
      fwd_core      <= '0;
      fwd_requester <= '0;
      fwd_addr      <= '0;
    end else begin
      rsp_valid     <= n_rsp_valid;
      rsp_core      <= widx;
      rsp_kind      <= n_rsp_kind;
      rsp_data      <= n_rsp_data;
      fwd_valid     <= n_fwd_valid;
      fwd_kind      <= n_fwd_kind;
      fwd_core      <= n_fwd_core;
      fwd_requester <= widx;
      fwd_addr      <= sel_addr;
    end
  end

  p_claim_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && sel_op == OP_CLAIM) |=>
      (rsp_valid && rsp_kind == RSP_ACK && rsp_core == $past(widx)));

  p_release_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && fwd_kind == FWD_RELEASE) |->
      (rsp_valid && rsp_kind == RSP_ACK && fwd_core != rsp_core));

  p_fwd_read_alone_r5: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && fwd_kind == FWD_READ) |-> !rsp_valid);

  p_wback_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && sel_op == OP_WBACK) |=> (!rsp_valid && !fwd_valid));

  p_nop_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && sel_op == OP_NOP) |=> (!rsp_valid && !fwd_valid));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (!rsp_valid && !fwd_valid));

endmodule

// File: tb/regdir_bank_test.sv
module regdir_bank_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0]        req_valid;
  logic [3:0]        req_ready;
  logic [3:0][1:0]   req_op;
  logic [3:0][3:0]   req_addr;
  logic [3:0][31:0]  req_wdata;
  logic              rsp_valid;
  logic [1:0]        rsp_core;
  logic              rsp_kind;
  logic [31:0]       rsp_data;
  logic              fwd_valid;
  logic              fwd_kind;
  logic [1:0]        fwd_core;
  logic [1:0]        fwd_requester;
  logic [3:0]        fwd_addr;

  regdir_bank uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data), .fwd_valid(fwd_valid), .fwd_kind(fwd_kind),
    .fwd_core(fwd_core), .fwd_requester(fwd_requester), .fwd_addr(fwd_addr)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // core, op, addr, wdata, rsp_v, rsp_kind, rsp_data, fwd_v, fwd_kind, fwd_core, req tag
  typedef struct packed {
    logic [1:0]  core;
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic        rv;
    logic        rk;
    logic [31:0] rd;
    logic        fv;
    logic        fk;
    logic [1:0]  fc;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 2'b01, 4'd3, 32'h0,         1'b1, 1'b1, 32'h0,         1'b0, 1'b0, 2'd0, 4'd3},  // R3 claim free word
    '{2'd1, 2'b10, 4'd3, 32'hA5A50001,  1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 4'd6},  // R6 owner write-back
    '{2'd2, 2'b00, 4'd3, 32'h0,         1'b1, 1'b0, 32'hA5A50001,  1'b0, 1'b0, 2'd0, 4'd2},  // R2 read data
    '{2'd0, 2'b01, 4'd3, 32'h0,         1'b1, 1'b1, 32'h0,         1'b0, 1'b0, 2'd0, 4'd3},  // R3
    '{2'd2, 2'b00, 4'd3, 32'h0,         1'b0, 1'b0, 32'h0,         1'b1, 1'b0, 2'd0, 4'd5},  // R5 forward to owner 0
    '{2'd3, 2'b01, 4'd3, 32'h0,         1'b1, 1'b1, 32'h0,         1'b1, 1'b1, 2'd0, 4'd4},  // R4 release to 0
    '{2'd0, 2'b10, 4'd3, 32'h0000DEAD,  1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 4'd7},  // R7 stale write-back
    '{2'd1, 2'b00, 4'd3, 32'h0,         1'b0, 1'b0, 32'h0,         1'b1, 1'b0, 2'd3, 4'd7},  // R7 still owned by 3
    '{2'd3, 2'b01, 4'd3, 32'h0,         1'b1, 1'b1, 32'h0,         1'b0, 1'b0, 2'd0, 4'd11}, // R11 re-claim
    '{2'd3, 2'b10, 4'd3, 32'h12345678,  1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 4'd6},  // R6
    '{2'd0, 2'b00, 4'd3, 32'h0,         1'b1, 1'b0, 32'h12345678,  1'b0, 1'b0, 2'd0, 4'd6},  // R6 data back
    '{2'd2, 2'b11, 4'd3, 32'hFFFFFFFF,  1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 4'd8},  // R8 no-op
    '{2'd0, 2'b00, 4'd3, 32'h0,         1'b1, 1'b0, 32'h12345678,  1'b0, 1'b0, 2'd0, 4'd8},  // R8 unchanged
    '{2'd2, 2'b01, 4'd7, 32'h0,         1'b1, 1'b1, 32'h0,         1'b0, 1'b0, 2'd0, 4'd3},  // R3
    '{2'd2, 2'b10, 4'd7, 32'hCAFEF00D,  1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 4'd6},  // R6
    '{2'd1, 2'b00, 4'd7, 32'h0,         1'b1, 1'b0, 32'hCAFEF00D,  1'b0, 1'b0, 2'd0, 4'd2},  // R2
    '{2'd1, 2'b00, 4'd3, 32'h0,         1'b1, 1'b0, 32'h12345678,  1'b0, 1'b0, 2'd0, 4'd2}   // R2 other word intact
  };

  task automatic drive_one(input logic [1:0] core, input logic [1:0] op,
                           input logic [3:0] addr, input logic [31:0] wdata);
    req_valid = '0;
    req_valid[core] = 1'b1;
    req_op[core]    = op;
    req_addr[core]  = addr;
    req_wdata[core] = wdata;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 32'(rsp_valid), 0);
    check(fwd_valid == 1'b0, "R9", "fwd_valid after reset", 32'(fwd_valid), 0);
    check(req_ready == 4'b0, "R1", "ready with no request", 32'(req_ready), 0);

    // R9: a fresh word is answered locally
    @(negedge clk);
    drive_one(2'd2, 2'b00, 4'd9, 32'h0);
    @(negedge clk);
    req_valid = '0;
    check(rsp_valid && rsp_kind == 1'b0 && rsp_core == 2'd2, "R9", "read after reset",
          {rsp_valid, rsp_kind, rsp_core}, {1'b1, 1'b0, 2'd2});
    check(fwd_valid == 1'b0, "R9", "no forward after reset", 32'(fwd_valid), 0);

    for (int v = 0; v < NV; v++) begin
      drive_one(VEC[v].core, VEC[v].op, VEC[v].addr, VEC[v].wdata);
      @(negedge clk);
      req_valid = '0;
      check(rsp_valid == VEC[v].rv, $sformatf("R%0d v%0d", VEC[v].rq, v), "rsp_valid",
            32'(rsp_valid), 32'(VEC[v].rv));
      if (VEC[v].rv) begin
        check(rsp_core == VEC[v].core && rsp_kind == VEC[v].rk,
              $sformatf("R%0d v%0d", VEC[v].rq, v), "rsp core/kind",
              {rsp_core, rsp_kind}, {VEC[v].core, VEC[v].rk});
        check(rsp_data == VEC[v].rd, $sformatf("R%0d v%0d", VEC[v].rq, v), "rsp_data",
              rsp_data, VEC[v].rd);
      end
      check(fwd_valid == VEC[v].fv, $sformatf("R%0d v%0d", VEC[v].rq, v), "fwd_valid",
            32'(fwd_valid), 32'(VEC[v].fv));
      if (VEC[v].fv) begin
        check(fwd_kind == VEC[v].fk && fwd_core == VEC[v].fc &&
              fwd_requester == VEC[v].core && fwd_addr == VEC[v].addr,
              $sformatf("R%0d v%0d", VEC[v].rq, v), "fwd kind/core/req/addr",
              {fwd_kind, fwd_core, fwd_requester, fwd_addr},
              {VEC[v].fk, VEC[v].fc, VEC[v].core, VEC[v].addr});
      end
    end

    // R1: all four cores read word 7 at once; served lowest index first
    begin
      logic [3:0] pending;
      pending = 4'hF;
      for (int c = 0; c < 4; c++) begin
        req_op[c] = 2'b00; req_addr[c] = 4'd7; req_wdata[c] = '0;
      end
      req_valid = pending;
      for (int k = 0; k < 4; k++) begin
        #1;
        check(req_ready == 4'(1 << k), "R1", "ready one-hot lowest", 32'(req_ready), 32'(1 << k));
        @(negedge clk);
        check(rsp_valid && rsp_core == 2'(k) && rsp_data == 32'hCAFEF00D, "R1", "grant order",
              {rsp_valid, rsp_core}, {1'b1, 2'(k)});
        pending[k] = 1'b0;
        req_valid = pending;
      end
    end

    // R10: idle cycle is quiet
    @(negedge clk);
    check(!rsp_valid && !fwd_valid, "R10", "idle outputs", {rsp_valid, fwd_valid}, 0);

    // R9: reset drops ownership of word 5
    drive_one(2'd1, 2'b01, 4'd5, 32'h0);
    @(negedge clk);
    req_valid = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive_one(2'd0, 2'b00, 4'd5, 32'h0);
    @(negedge clk);
    req_valid = '0;
    check(rsp_valid && !fwd_valid, "R9", "owned word cleared by reset",
          {rsp_valid, fwd_valid}, {1'b1, 1'b0});

    finish_run();
  end

endmodule